// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Sensing

This block is a 32-pin general-purpose I/O port that sits on a simple single-cycle 32-bit register bus. Software picks the direction of each pin and the value that output pins drive. Input pads pass through a two-flop synchronizer and are kept in a pad-status register. Every input pin has its own interrupt sense mode: low level, high level, rising edge or falling edge. An optional any-edge register, when present, overrides that mode for the pins it selects.

Sense hits set sticky status flags. Software clears a flag by writing a one to it. Each flag is then gated by a mask bit, and the masked flags are OR-reduced into one interrupt line. A build option splits this into two lines, one per half of the port. Level conditions are evaluated on every clock. A level source that is still active after its flag is cleared, or after a configuration write, therefore raises its flag again at once.

Top module: `gpio_irq_port`

## Requirements
- R1: `pad_oe` equals the direction register (offset 0x04, 1 = output) and `pad_out` equals the data register (offset 0x00), one cycle after the write.
- R2: A pin whose direction bit is 1 never sets its status flag, whatever its sense mode and pad level.
- R3: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Offset 0x00 returns the data bit for output pins and the pad-status bit for input pins. Offset 0x08 returns the pad status with output positions forced to 0. Offsets that are not word aligned, or that lie at 0x20 and above, read as 0 and ignore writes.
- R4: Pin i's sense code is held in bits [2i+1:2i] of the word formed by 0x10 (upper 32 bits) and 0x0C (lower 32 bits). Code 00 flags while the pad is low, and code 01 flags while the pad is high.
- R5: Code 10 flags a rising pad edge and code 11 flags a falling pad edge. The opposite edge leaves the flag clear.
- R6: When bit i of the any-edge register (offset 0x1C) is 1, pin i ignores its sense code and flags on both pad edges.
- R7: Status flags (offset 0x18) are sticky, and writing 1 to a flag clears it. A level source that is still active sets its flag again immediately after the clear.
- R8: If a hardware hit and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R9: With the split option off, `irq[0]` is the OR of status AND mask (offset 0x14), and `irq[1]` stays 0.
- R10: With the split option on, `irq[0]` covers pins 0 to 15 and `irq[1]` covers pins 16 to 31.
- R11: When the any-edge register is built out, offset 0x1C reads 0, writes to it have no effect, and every pin follows its sense code.
- R12: Reset clears every register, pad status included. A pad change is seen as a hit on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output pad values |
| pad_oe | output | 32 | Output enable per pad |
| irq | output | 2 | Interrupt lines |

## Verification
Two things can reach the same status flag in one clock: a hardware hit from the detector and a software write-one-to-clear. The bench provokes the collision by counting synchronizer stages from a rising pad edge, so that the clear write lands on exactly the edge where the rising hit is registered. The flag must read back as set. A plain clear with no hit must still empty it. The same race happens in a quieter way whenever a still-active level source is cleared. That case is judged by reading the flag straight after the clear and expecting it to be set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS   = 32;
    localparam int HALF   = PINS / 2;
    localparam int ADDR_W = 6;
    localparam int MAP_SZ = 32;

    localparam logic [ADDR_W-1:0] OFF_DATA   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_PAD    = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_CFG_LO = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_CFG_HI = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_FLAG   = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_ANY    = 6'h1C;

    typedef logic [PINS-1:0] pinvec_t;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_t;

    typedef enum logic [3:0] {
        REG_DATA   = 4'd0,
        REG_DIR    = 4'd1,
        REG_PAD    = 4'd2,
        REG_CFG_LO = 4'd3,
        REG_CFG_HI = 4'd4,
        REG_MASK   = 4'd5,
        REG_FLAG   = 4'd6,
        REG_ANY    = 4'd7,
        REG_NONE   = 4'd8
    } reg_sel_t;

    typedef struct packed {
        pinvec_t             dir;
        pinvec_t             dout;
        logic [2*PINS-1:0]   cfg;
        pinvec_t             mask;
    } port_cfg_t;

    function automatic reg_sel_t decode_off(logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00 || a >= ADDR_W'(MAP_SZ))
            return REG_NONE;
        return reg_sel_t'({1'b0, a[4:2]});
    endfunction

    function automatic logic sense_hit(sense_t code, logic now, logic prev);
        case (code)
            SENSE_LOW:  return ~now;
            SENSE_HIGH: return now;
            SENSE_RISE: return now & ~prev;
            default:    return ~now & prev;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]   now,
    input  logic [N-1:0]   prev,
    input  logic [N-1:0]   dir,
    input  logic [N-1:0]   any_edge,
    input  logic [2*N-1:0] cfg,
    output logic [N-1:0]   hit
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic by_code;
        assign by_code = sense_hit(sense_t'(cfg[2*i +: 2]), now[i], prev[i]);
        assign hit[i]  = dir[i]      ? 1'b0 :
                         any_edge[i] ? (now[i] ^ prev[i]) :
                                       by_code;
    end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int N     = 32,
    parameter bit SPLIT = 1'b0
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic [1:0]   irq
);
    localparam int H = N / 2;
    logic [N-1:0] pend;

    assign pend = flags & mask;

    if (SPLIT) begin : g_split
        assign irq = {|pend[N-1:H], |pend[H-1:0]};
    end else begin : g_single
        assign irq = {1'b0, |pend};
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter bit HAS_ANY_EDGE = 1'b1,
    parameter bit SPLIT_IRQ    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [1:0]        irq
);
    port_cfg_t cfg_q;
    pinvec_t   pad_s, psr_q, isr_q, any_q, hit, clr, rd_mux;
    reg_sel_t  sel;

    assign sel = decode_off(bus_addr);
    assign clr = (bus_wr && sel == REG_FLAG) ? bus_wdata : '0;

    gpio_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_s)
    );

    gpio_detect #(.N(PINS)) u_detect (
        .now      (pad_s),
        .prev     (psr_q),
        .dir      (cfg_q.dir),
        .any_edge (any_q),
        .cfg      (cfg_q.cfg),
        .hit      (hit)
    );

    gpio_irq_merge #(.N(PINS), .SPLIT(SPLIT_IRQ)) u_merge (
        .flags (isr_q),
        .mask  (cfg_q.mask),
        .irq   (irq)
    );

    if (HAS_ANY_EDGE) begin : g_any
        always_ff @(posedge clk) begin
            if (rst)
                any_q <= '0;
            else if (bus_wr && sel == REG_ANY)
                any_q <= bus_wdata;
        end
    end else begin : g_no_any
        assign any_q = '0;
    end

    always_comb begin
        case (sel)
            REG_DATA:   rd_mux = (cfg_q.dout & cfg_q.dir) | (psr_q & ~cfg_q.dir);
            REG_DIR:    rd_mux = cfg_q.dir;
            REG_PAD:    rd_mux = psr_q & ~cfg_q.dir;
            REG_CFG_LO: rd_mux = cfg_q.cfg[PINS-1:0];
            REG_CFG_HI: rd_mux = cfg_q.cfg[2*PINS-1:PINS];
            REG_MASK:   rd_mux = cfg_q.mask;
            REG_FLAG:   rd_mux = isr_q;
            REG_ANY:    rd_mux = any_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            psr_q     <= '0;
            isr_q     <= '0;
            bus_rdata <= '0;
        end else begin
            psr_q <= pad_s;
            isr_q <= (isr_q & ~clr) | hit;
            if (bus_rd)
                bus_rdata <= rd_mux;
            if (bus_wr) begin
                case (sel)
                    REG_DATA:   cfg_q.dout <= bus_wdata;
                    REG_DIR:    cfg_q.dir  <= bus_wdata;
                    REG_CFG_LO: cfg_q.cfg[PINS-1:0]      <= bus_wdata;
                    REG_CFG_HI: cfg_q.cfg[2*PINS-1:PINS] <= bus_wdata;
                    REG_MASK:   cfg_q.mask <= bus_wdata;
                    default:    ;
                endcase
            end
        end
    end

    assign pad_out = cfg_q.dout;
    assign pad_oe  = cfg_q.dir;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_pkg::*;
#(
    parameter bit SPLIT_IRQ = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [1:0]        irq,
    input logic [PINS-1:0]   isr,
    input logic [PINS-1:0]   dir,
    input logic [PINS-1:0]   imr
);
    p_oe_tracks_dir_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_DIR) |=> pad_oe == $past(bus_wdata));

    p_out_tracks_data_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_DATA) |=> pad_out == $past(bus_wdata));

    p_no_output_flag_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((isr & ~$past(isr) & $past(dir)) == '0));

    p_unaligned_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFF_FLAG) |=> ((isr & $past(isr)) == $past(isr)));

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq[0] |-> ((isr & imr) != '0));

    if (!SPLIT_IRQ) begin : g_single
        p_upper_line_idle_r9: assert property (@(posedge clk) disable iff (rst)
            !irq[1]);
    end else begin : g_split
        p_upper_line_source_r10: assert property (@(posedge clk) disable iff (rst)
            irq[1] |-> ((isr[PINS-1:HALF] & imr[PINS-1:HALF]) != '0));
    end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.SPLIT_IRQ(SPLIT_IRQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .isr       (isr_q),
    .dir       (cfg_q.dir),
    .imr       (cfg_q.mask)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pads = '0;
    logic [31:0] rdata, rdata_alt, pad_out, pad_oe, pad_out_alt, pad_oe_alt;
    logic [1:0]  irq, irq_alt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_port dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    gpio_irq_port #(.HAS_ANY_EDGE(1'b0), .SPLIT_IRQ(1'b1)) dut_alt (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_alt),
        .pad_in(pads), .pad_out(pad_out_alt), .pad_oe(pad_oe_alt), .irq(irq_alt)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic setup_pin(int k, logic [1:0] code, bit anyf);
        logic [63:0] cfgv;
        for (int i = 0; i < 32; i++)
            cfgv[2*i +: 2] = (i == k) ? code : 2'b01;
        wr(6'h04, 32'h0);
        wr(6'h0C, cfgv[31:0]);
        wr(6'h10, cfgv[63:32]);
        wr(6'h1C, anyf ? (32'h1 << k) : 32'h0);
        wr(6'h14, 32'h1 << k);
        settle();
        wr(6'h18, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: everything cleared under reset
        chk("R12 reset rdata", rdata, 32'h0);
        chk("R12 reset pad_oe", pad_oe, 32'h0);
        chk("R12 reset pad_out", pad_out, 32'h0);
        chk("R12 reset irq", {30'h0, irq}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        rd(6'h14);
        chk("R12 mask after reset", rdata, 32'h0);
        rd(6'h0C);
        chk("R12 cfg after reset", rdata, 32'h0);

        // R1: direction and data drive the pads
        wr(6'h04, 32'hF0F0_1234);
        wr(6'h00, 32'hA5A5_5A5A);
        chk("R1 pad_oe", pad_oe, 32'hF0F0_1234);
        chk("R1 pad_out", pad_out, 32'hA5A5_5A5A);
        rd(6'h04);
        chk("R1 dir readback", rdata, 32'hF0F0_1234);

        // R3: read multiplexing and unknown offsets
        pads = 32'h3C3C_C3C3;
        settle();
        rd(6'h00);
        chk("R3 data mix", rdata,
            (32'hA5A5_5A5A & 32'hF0F0_1234) | (32'h3C3C_C3C3 & ~32'hF0F0_1234));
        rd(6'h08);
        chk("R3 pad status", rdata, 32'h3C3C_C3C3 & ~32'hF0F0_1234);
        rd(6'h20);
        chk("R3 high offset", rdata, 32'h0);
        rd(6'h06);
        chk("R3 unaligned", rdata, 32'h0);
        wr(6'h24, 32'hFFFF_FFFF);
        wr(6'h05, 32'hFFFF_FFFF);
        rd(6'h04);
        chk("R3 unknown write ignored", rdata, 32'hF0F0_1234);
        rd(6'h00);
        chk("R3 data unchanged", pad_out, 32'hA5A5_5A5A);
        pads = 32'h0;
        wr(6'h00, 32'h0);

        // R2: output pin with active low-level code stays clear
        wr(6'h0C, 32'h0);
        wr(6'h10, 32'h0);
        wr(6'h04, 32'h0000_0080);
        settle();
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18);
        chk("R2 output pin flag", rdata, 32'hFFFF_FF7F);

        // R11: any-edge register presence
        wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h1C);
        chk("R11 present readback", rdata, 32'hFFFF_FFFF);
        chk("R11 absent reads zero", rdata_alt, 32'h0);
        wr(6'h1C, 32'h0);

        // Sweep every pin through every sense mode
        for (int k = 0; k < 32; k++) begin
            for (int m = 0; m < 5; m++) begin
                logic [1:0] code;
                bit anyf;
                bit a_e, b_e, c_e, d_e, a_a, b_a, c_a, d_a;
                string tg;
                code = (m == 4) ? 2'b10 : m[1:0];
                anyf = (m == 4);
                tg = anyf ? "R6" : (code[1] ? "R5" : "R4");
                a_e = !anyf && code == 2'b00;
                c_e = !anyf && code == 2'b01;
                b_e = a_e | c_e | anyf | (code == 2'b10);
                d_e = c_e | a_e | anyf | (code == 2'b11);
                a_a = code == 2'b00;
                c_a = code == 2'b01;
                b_a = a_a | c_a | (code == 2'b10);
                d_a = c_a | a_a | (code == 2'b11);
                setup_pin(k, code, anyf);
                rd(6'h18);
                chk({tg, " steady low"}, rdata, 32'(a_e) << k);
                chk("R11 alt steady low", rdata_alt, 32'(a_a) << k);
                pads[k] = 1'b1;
                settle();
                rd(6'h18);
                chk({tg, " after rise"}, rdata, 32'(b_e) << k);
                chk("R11 alt after rise", rdata_alt, 32'(b_a) << k);
                chk("R9 irq single", {30'h0, irq}, {31'h0, b_e});
                chk("R10 irq split", {30'h0, irq_alt},
                    (k >= 16) ? {30'h0, b_a, 1'b0} : {31'h0, b_a});
                wr(6'h18, 32'hFFFF_FFFF);
                rd(6'h18);
                chk("R7 reflag after clear", rdata, 32'(c_e) << k);
                pads[k] = 1'b0;
                settle();
                rd(6'h18);
                chk({tg, " after fall"}, rdata, 32'(d_e) << k);
                chk("R11 alt after fall", rdata_alt, 32'(d_a) << k);
                wr(6'h18, 32'hFFFF_FFFF);
            end
        end

        // R12: hit appears on the third rising edge after a pad change
        setup_pin(5, 2'b10, 1'b0);
        pads[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12 two edges no irq", {30'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R12 third edge irq", {30'h0, irq}, 32'h1);
        pads[5] = 1'b0;
        settle();

        // R8: hit and clear on the same edge
        setup_pin(9, 2'b10, 1'b0);
        pads[9] = 1'b1;
        @(negedge clk);
        wr(6'h18, 32'h0000_0200);
        rd(6'h18);
        chk("R8 set wins over clear", rdata, 32'h0000_0200);
        wr(6'h18, 32'h0000_0200);
        rd(6'h18);
        chk("R7 plain clear", rdata, 32'h0);
        pads[9] = 1'b0;
        settle();

        // R10: split lines on high-level pins 3 and 20
        wr(6'h0C, 32'h5555_5555);
        wr(6'h10, 32'h5555_5555);
        wr(6'h14, 32'h0010_0008);
        wr(6'h18, 32'hFFFF_FFFF);
        pads = 32'h0000_0008;
        settle();
        chk("R10 low half only", {30'h0, irq_alt}, 32'h1);
        pads = 32'h0010_0008;
        settle();
        chk("R10 both halves", {30'h0, irq_alt}, 32'h3);
        chk("R9 single line", {30'h0, irq}, 32'h1);
        pads = 32'h0010_0000;
        settle();
        wr(6'h18, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 high half only", {30'h0, irq_alt}, 32'h2);
        chk("R9 upper line idle", {30'h0, irq}, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule